// File: doc/BRIEF.md
# Rotate Unit with Extend Flag

This execution unit performs the rotate group of a 32-bit data-register machine. It covers plain rotates and rotates that pass through the extend bit, in left and right directions, at byte, word and long operand sizes. It also handles a word-only memory form that rotates by one. The caller supplies the 16-bit instruction word, the destination register value, the value of the count register, the current extend flag and, for the memory form, the 16-bit memory operand. The unit decodes the word, computes the result and the flags combinationally, and presents everything registered one cycle after a valid strobe.

When a rotate goes through the extend bit, the operand and X together form a ring of size+1 bits (9, 17 or 33). The count is therefore reduced modulo that ring length, and the carry and extend flags both receive the last bit rotated out. A plain rotate is a true size-bit ring that leaves X unchanged. Byte and word results replace only the low part of the register.

Top module: `rot_x_unit`

## Requirements
- R1: A word is recognised when (op & 16'hF0F0) equals one of 16'hE010, E030, E050, E070, E090 or E0B0, or when (op & 16'hFCC0) equals 16'hE4C0. In the register and immediate forms, bits 7:6 give the size (00 byte, 01 word, 10 long) and bit 5 set selects a count taken from the register. A recognised word with in_valid high raises out_valid one cycle later. An unrecognised word leaves out_valid low and the outputs unchanged.
- R2: In the immediate forms the count is op[11:9], and a field value of 0 means a count of 8.
- R3: op[8] set rotates left, and op[8] clear rotates right.
- R4: In the register and immediate forms, op[3] set selects a plain rotate and op[3] clear selects a rotate through X. In the memory form, op[9] makes that choice.
- R5: A register count uses cnt_val[5:0]. A plain rotate reduces it modulo the size. A rotate through X reduces it modulo size+1 (9, 17 or 33).
- R6: A plain rotate leaves X unchanged and clears V. N is the sign bit and Z the zero test of the sized result. C is the result's lsb after a left rotate and its msb after a right rotate.
- R7: A plain rotate with a register count whose 6-bit value is zero clears C and leaves the register value unchanged.
- R8: A rotate through X sets C and X to the last bit rotated out, clears V, and sets N and Z from the sized result.
- R9: A rotate through X whose reduced count is zero leaves the register and X unchanged, and C takes the value of X.
- R10: Byte and word results replace only bits 7:0 or 15:0 of res_val. The upper bits carry dst_val unchanged.
- R11: The memory form rotates mem_opnd by exactly one bit and returns the result on mem_res. In that form res_val equals dst_val. In all other forms mem_res is zero.
- R12: After reset, out_valid, res_val, mem_res and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_word | input | 16 | Instruction word |
| dst_val | input | 32 | Destination register value |
| cnt_val | input | 32 | Count register value |
| x_in | input | 1 | Current extend flag |
| mem_opnd | input | 16 | Memory operand for the memory form |
| out_valid | output | 1 | Registered results are valid |
| res_val | output | 32 | New destination register value |
| mem_res | output | 16 | Rotated memory operand |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always cleared) |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
The bench builds the unit with the package defaults: a 32-bit register, a 16-bit instruction word and a 6-bit register count. These fix the three ring lengths at 9, 17 and 33. Because only 64 register counts exist, the bench sweeps every one of them for each size, direction and mode, so every residue of both reductions is reached, including the wrap points at 8, 9, 16, 17, 32 and 33. The reference model rotates one bit per step for the full unreduced count, so it never shares the modulo arithmetic with the design.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int DATA_W = 32;
  localparam int OP_W   = 16;
  localparam int CNT_W  = 6;
  localparam int NSIZE  = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } rot_size_e;

  typedef struct packed {
    logic             hit;
    logic             is_mem;
    rot_size_e        size;
    logic             left;
    logic             plain;
    logic             reg_cnt;
    logic [CNT_W-1:0] cnt;
  } rot_dec_t;

  // Width of the operand for a size code
  function automatic int size_bits(input rot_size_e s);
    case (s)
      SZ_BYTE: size_bits = 8;
      SZ_WORD: size_bits = 16;
      default: size_bits = 32;
    endcase
  endfunction
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [OP_W-1:0]   op_word,
  input  logic [DATA_W-1:0] cnt_val,
  output rot_dec_t          dec
);
  localparam logic [OP_W-1:0] RR_MASK  = 16'hF0F0;
  localparam logic [OP_W-1:0] MEM_MASK = 16'hFCC0;
  localparam logic [OP_W-1:0] MEM_VAL  = 16'hE4C0;

  logic [OP_W-1:0]  rr_bits;
  logic             rr_hit;
  logic             mem_hit;
  logic [2:0]       imm_field;
  logic [CNT_W-1:0] imm_cnt;

  assign rr_bits   = op_word & RR_MASK;
  assign mem_hit   = (op_word & MEM_MASK) == MEM_VAL;
  assign imm_field = op_word[11:9];
  assign imm_cnt   = (imm_field == 3'd0) ? CNT_W'(8) : CNT_W'(imm_field);

  always_comb begin
    case (rr_bits)
      16'hE010, 16'hE030, 16'hE050,
      16'hE070, 16'hE090, 16'hE0B0: rr_hit = 1'b1;
      default:                      rr_hit = 1'b0;
    endcase
  end

  always_comb begin
    dec.hit     = rr_hit | mem_hit;
    dec.is_mem  = mem_hit;
    dec.left    = op_word[8];
    if (mem_hit) begin
      dec.size    = SZ_WORD;
      dec.plain   = op_word[9];
      dec.reg_cnt = 1'b0;
      dec.cnt     = CNT_W'(1);
    end else begin
      dec.size    = rot_size_e'(op_word[7:6]);
      dec.plain   = op_word[3];
      dec.reg_cnt = op_word[5];
      dec.cnt     = op_word[5] ? cnt_val[CNT_W-1:0] : imm_cnt;
    end
  end
endmodule

// File: rtl/rot_core.sv
module rot_core #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     opnd,
  input  logic             left,
  input  logic             plain,
  input  logic             reg_cnt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             x_in,
  output logic [W-1:0]     res,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             x_out,
  output logic             ring_zero
);
  localparam int RING = W + 1;

  function automatic logic [W-1:0] rot_w(input logic [W-1:0] v, input int k,
                                         input logic lft);
    logic [2*W-1:0] t;
    if (lft) begin
      t = {v, v} << k;
      rot_w = t[2*W-1:W];
    end else begin
      t = {v, v} >> k;
      rot_w = t[W-1:0];
    end
  endfunction

  function automatic logic [RING-1:0] rot_ring(input logic [RING-1:0] v,
                                               input int k, input logic lft);
    logic [2*RING-1:0] t;
    if (lft) begin
      t = {v, v} << k;
      rot_ring = t[2*RING-1:RING];
    end else begin
      t = {v, v} >> k;
      rot_ring = t[RING-1:0];
    end
  endfunction

  int            k_plain;
  int            k_ring;
  logic [W-1:0]  plain_res;
  logic [RING-1:0] ring_res;

  always_comb begin
    k_plain   = int'(cnt) % W;
    k_ring    = int'(cnt) % RING;
    ring_zero = (k_ring == 0);
    plain_res = rot_w(opnd, k_plain, left);
    ring_res  = rot_ring({x_in, opnd}, k_ring, left);
    if (plain) begin
      res   = plain_res;
      x_out = x_in;
      if (reg_cnt && cnt == '0) c_out = 1'b0;
      else                      c_out = left ? plain_res[0] : plain_res[W-1];
    end else begin
      res   = ring_res[W-1:0];
      x_out = ring_res[W];
      c_out = ring_res[W];
    end
    n_out = res[W-1];
    z_out = (res == '0);
  end
endmodule

// File: rtl/rot_x_unit.sv
module rot_x_unit
  import rot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_word,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              x_in,
  input  logic [15:0]       mem_opnd,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_val,
  output logic [15:0]       mem_res,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_x
);
  rot_dec_t dec;

  rot_decode u_dec (
    .op_word (op_word),
    .cnt_val (cnt_val),
    .dec     (dec)
  );

  logic [DATA_W-1:0] core_src [NSIZE];
  logic [DATA_W-1:0] core_res [NSIZE];
  logic [NSIZE-1:0]  core_n, core_z, core_c, core_x, core_rz;

  assign core_src[0] = dst_val;
  assign core_src[1] = dec.is_mem ? {16'b0, mem_opnd} : dst_val;
  assign core_src[2] = dst_val;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W = 8 << g;
    logic [W-1:0] r;
    rot_core #(.W(W), .CNT_W(CNT_W)) u_core (
      .opnd      (core_src[g][W-1:0]),
      .left      (dec.left),
      .plain     (dec.plain),
      .reg_cnt   (dec.reg_cnt),
      .cnt       (dec.cnt),
      .x_in      (x_in),
      .res       (r),
      .n_out     (core_n[g]),
      .z_out     (core_z[g]),
      .c_out     (core_c[g]),
      .x_out     (core_x[g]),
      .ring_zero (core_rz[g])
    );
    assign core_res[g] = DATA_W'(r);
  end

  // Selected per-size outputs, brought out for the checks below
  logic              sel_n, sel_z, sel_c, sel_x, sel_rz;
  logic [DATA_W-1:0] sel_val;
  logic [15:0]       sel_mem;
  logic              accept;

  assign accept = in_valid & dec.hit;

  always_comb begin
    sel_n  = core_n[dec.size];
    sel_z  = core_z[dec.size];
    sel_c  = core_c[dec.size];
    sel_x  = core_x[dec.size];
    sel_rz = core_rz[dec.size];
    sel_mem = '0;
    case (dec.size)
      SZ_BYTE: sel_val = {dst_val[DATA_W-1:8],  core_res[0][7:0]};
      SZ_WORD: sel_val = {dst_val[DATA_W-1:16], core_res[1][15:0]};
      default: sel_val = core_res[2];
    endcase
    if (dec.is_mem) begin
      sel_val = dst_val;
      sel_mem = core_res[1][15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_val   <= '0;
      mem_res   <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      flag_x    <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        res_val <= sel_val;
        mem_res <= sel_mem;
        flag_n  <= sel_n;
        flag_z  <= sel_z;
        flag_v  <= 1'b0;
        flag_c  <= sel_c;
        flag_x  <= sel_x;
      end
    end
  end

  // R1
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec.hit) |=> !out_valid);
  // R6
  plain_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.plain) |=> (flag_x == $past(x_in)));
  // R8
  v_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flag_v);
  // R8
  ring_c_eq_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.plain) |=> (flag_c == flag_x));
  // R9
  ring_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.plain && sel_rz && !dec.is_mem) |=>
      (res_val == $past(dst_val) && flag_x == $past(x_in)));
  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.is_mem && dec.size == SZ_BYTE) |=>
      (res_val[DATA_W-1:8] == $past(dst_val[DATA_W-1:8])));
  // R7
  plain_zero_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.plain && dec.reg_cnt && cnt_val[CNT_W-1:0] == '0) |=>
      (!flag_c && res_val == $past(dst_val)));
endmodule

// File: tb/sim_rot_x_unit.sv
module sim_rot_x_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_word = '0;
  logic [31:0] dst_val = '0;
  logic [31:0] cnt_val = '0;
  logic        x_in = 1'b0;
  logic [15:0] mem_opnd = '0;
  logic        out_valid;
  logic [31:0] res_val;
  logic [15:0] mem_res;
  logic        flag_n, flag_z, flag_v, flag_c, flag_x;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rot_x_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_word(op_word),
    .dst_val(dst_val), .cnt_val(cnt_val), .x_in(x_in), .mem_opnd(mem_opnd),
    .out_valid(out_valid), .res_val(res_val), .mem_res(mem_res),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .flag_x(flag_x)
  );

  // Bit-serial model: steps one bit per iteration for the full count
  task automatic ref_model(input logic [15:0] op, input logic [31:0] d,
                           input logic [31:0] cv, input logic xi,
                           input logic [15:0] mo, output logic hit,
                           output logic [54:0] exp_v);
    logic is_mem, rr, plain, left;
    int w, steps;
    logic [31:0] v, mask, rv;
    logic [15:0] mr;
    logic c, x, o;
    is_mem = (op & 16'hFCC0) == 16'hE4C0;
    rr = ((op & 16'hF0F0) inside {16'hE010, 16'hE030, 16'hE050,
                                  16'hE070, 16'hE090, 16'hE0B0});
    hit = is_mem | rr;
    left = op[8];
    if (is_mem) begin
      w = 16; plain = op[9]; steps = 1;
    end else begin
      w = (op[7:6] == 2'b00) ? 8 : (op[7:6] == 2'b01) ? 16 : 32;
      plain = op[3];
      steps = op[5] ? int'(cv[5:0]) : ((op[11:9] == 0) ? 8 : int'(op[11:9]));
    end
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v = is_mem ? {16'b0, mo} : (d & mask);
    x = xi;
    c = plain ? 1'b0 : xi;
    for (int i = 0; i < steps; i++) begin
      if (left) begin
        o = v[w-1];
        v = ((v << 1) & mask) | {31'b0, plain ? o : x};
      end else begin
        o = v[0];
        v = (v >> 1) | ((plain ? {31'b0, o} : {31'b0, x}) << (w - 1));
      end
      c = o;
      if (!plain) x = o;
    end
    rv = is_mem ? d : ((d & ~mask) | v);
    mr = is_mem ? v[15:0] : 16'h0;
    exp_v = {rv, mr, v[w-1], (v == 0), 1'b0, c, x};
  endtask

  task automatic apply_chk(input logic [15:0] op, input logic [31:0] d,
                           input logic [31:0] cv, input logic xi,
                           input logic [15:0] mo, input string req);
    logic hit;
    logic [54:0] e, a;
    ref_model(op, d, cv, xi, mo, hit, e);
    op_word = op; dst_val = d; cnt_val = cv; x_in = xi; mem_opnd = mo;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    a = {res_val, mem_res, flag_n, flag_z, flag_v, flag_c, flag_x};
    if (!out_valid || a != e) begin
      errors++;
      $display("FAIL %s op=%h cnt=%0d: valid=%b act=%h exp=%h", req, op,
               cv[5:0], out_valid, a, e);
    end
  endtask

  task automatic test_reset();
    checks++;
    if (out_valid || res_val != 0 || mem_res != 0 ||
        {flag_n, flag_z, flag_v, flag_c, flag_x} != 0) begin
      errors++;
      $display("FAIL R12 reset state act=%b/%h exp=0", out_valid, res_val);
    end
  endtask

  // R2 R3 R4 R6 R8 R10: immediate forms, every field value
  task automatic test_immediate();
    for (int sz = 0; sz < 3; sz++)
      for (int f = 0; f < 8; f++)
        for (int m = 0; m < 4; m++) begin
          logic [15:0] op;
          op = 16'hE010 | 16'(f << 9) | 16'(sz << 6) | 16'((m & 1) << 8)
               | 16'(((m >> 1) & 1) << 3);
          apply_chk(op, $urandom, 32'h0, m[0] ^ f[0], 16'h0, "R2");
        end
  endtask

  // R5 R7 R9 R10: register count sweep over all 64 counts
  task automatic test_reg_sweep();
    for (int sz = 0; sz < 3; sz++)
      for (int cnt = 0; cnt < 64; cnt++)
        for (int m = 0; m < 4; m++) begin
          logic [15:0] op;
          op = 16'hE030 | 16'(sz << 6) | 16'((m & 1) << 8)
               | 16'(((m >> 1) & 1) << 3) | 16'(cnt & 7);
          apply_chk(op, $urandom, {$urandom, 6'(cnt)} , cnt[1], 16'h0, "R5");
        end
  endtask

  // R7 R9: zero-count corners with the high count bits set
  task automatic test_zero_counts();
    apply_chk(16'hE138, 32'h8000_0001, 32'hFFFF_FFC0, 1'b1, 16'h0, "R7");
    apply_chk(16'hE0B0, 32'h1234_5678, 32'h0000_0021, 1'b1, 16'h0, "R9");
    apply_chk(16'hE170, 32'hABCD_0000, 32'h0000_0011, 1'b0, 16'h0, "R9");
    apply_chk(16'hE030, 32'hFFFF_FF80, 32'h0000_0009, 1'b1, 16'h0, "R9");
  endtask

  // R11: memory form, both modes and directions
  task automatic test_memory();
    for (int m = 0; m < 4; m++) begin
      apply_chk(16'hE4C0 | 16'((m & 1) << 8) | 16'(((m >> 1) & 1) << 9),
                32'hDEAD_BEEF, 32'h5, 1'b1, 16'h8001, "R11");
      apply_chk(16'hE4D0 | 16'((m & 1) << 8) | 16'(((m >> 1) & 1) << 9),
                32'h0, 32'h5, 1'b0, 16'h4000, "R11");
    end
  endtask

  // R1: unrecognised words produce no result and leave outputs unchanged
  task automatic test_unknown();
    logic [31:0] held;
    held = res_val;
    op_word = 16'hE0C8; dst_val = 32'h5555_5555; cnt_val = 3; in_valid = 1'b1;
    @(negedge clk);
    op_word = 16'hE008;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid || res_val != held) begin
      errors++;
      $display("FAIL R1 unknown op valid=%b res=%h exp valid=0 res=%h",
               out_valid, res_val, held);
    end
  endtask

  initial begin
    repeat (1_000_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_immediate();
    test_reg_sweep();
    test_zero_counts();
    test_memory();
    test_unknown();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule